// File: doc/BRIEF.md
# Short-Pulse Input Synchronizer

This block brings an input that has no timing relation to the system clock into the system clock domain, even when the input is active for less than one clock period. Plain two-flop sampling can miss a pulse that narrow. Here the input's own active edge clocks a capture flip-flop, whose data is held at the "seen" value. The captured flag then passes through a chain of system-clock flip-flops. The chain gives the first stage a full cycle to settle out of metastability before the result is used.

Once the synchronized result is high, the capture flag is cleared asynchronously. The clear is blocked while the input is still active, so a long pulse is never cut short. Any further pulses that arrive while the flag is set merge into the event already in flight. A parameter selects whether the active event is a rising edge or a falling edge of the input. The output always reports an event as a high level.

Top module: `short_pulse_sync`

## Requirements
- R1: While `rst_n` is low, `sync_out` is 0 after the next clock edge and the capture flag is held clear, so an input pulse seen during reset produces no output event after reset is released.
- R2: With the input idle (low for the rising variant, high for the falling variant), `sync_out` stays 0.
- R3: A captured input edge between system clock edges k and k+1 makes `sync_out` 1 after edge k+2, which is the second clock edge after the capture.
- R4: Every output event lasts at least two clock cycles. For an input pulse that returns idle before `sync_out` rises, the event lasts exactly two cycles.
- R5: For an input held active across several clock edges, `sync_out` stays 1 until the input returns idle. It falls on the second clock edge after the input returns idle, so a pulse of L cycles (L ≥ 2) gives an output high for L cycles.
- R6: Several pulses that all arrive before `sync_out` rises produce one output event, with the timing of the first pulse.
- R7: The capture flag is cleared only while `sync_out` is 1 and the input is idle.
- R8: With parameter `EDGE = EDGE_FALL`, the block captures falling edges of an input that idles high. It has the same latency and widths as the rising variant, and the output remains active-high.
- R9: A pulse shorter than one clock period produces exactly one output event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; synchronous for the chain, and it forces the capture flag clear |
| async_in | input | 1 | Input with no timing relation to `clk`; may be active for less than a clock period |
| sync_out | output | 1 | Synchronized event level in the `clk` domain |

## Verification
The bench builds two copies side by side, both with the default two-stage chain. One uses `EDGE = EDGE_RISE` and the other `EDGE = EDGE_FALL`, so both capture polarities and their opposite-sense clear terms are exercised under the same scenarios. With the two-stage chain, the expected latency (second edge after capture) and the exact widths for short and held pulses can be computed directly. This lets the bench measure sub-cycle pulses, held pulses and bursts against fixed cycle counts.

// File: rtl/short_pulse_sync_pkg.sv
// Shared types for the short-pulse synchronizer.
package short_pulse_sync_pkg;
    // Which input transition counts as an event.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;
endpackage

// File: rtl/pulse_capture.sv
// pulse_capture: a flip-flop clocked by the input's active edge, which
// records that the edge happened. It is cleared asynchronously by reset, or
// by the release request once the input is back at its idle level.
// Assumes release_i comes from the system clock domain.
module pulse_capture
    import short_pulse_sync_pkg::*;
#(
    parameter edge_sel_e EDGE = EDGE_RISE
) (
    input  logic async_in,
    input  logic rst_n,
    input  logic release_i,
    output logic flag_o
);
    logic input_idle;
    logic clear_req;

    // Idle level of the input depends on the chosen polarity.
    assign input_idle = (EDGE == EDGE_RISE) ? ~async_in : async_in;

    // Clear on reset, or when the result is out and the input has gone idle.
    assign clear_req = ~rst_n | (release_i & input_idle);

    generate
        if (EDGE == EDGE_RISE) begin : g_rise
            // Set on a rising input edge, clear asynchronously.
            always_ff @(posedge async_in or posedge clear_req) begin
                if (clear_req) flag_o <= 1'b0;
                else           flag_o <= 1'b1;
            end
        end else begin : g_fall
            // Set on a falling input edge, clear asynchronously.
            always_ff @(negedge async_in or posedge clear_req) begin
                if (clear_req) flag_o <= 1'b0;
                else           flag_o <= 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/sync_chain.sv
// sync_chain: a shift register of STAGES flip-flops on the system clock,
// used to resolve metastability. Synchronous active-low reset.
// Assumes STAGES >= 2.
module sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic first_o,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] shreg;

    // Shift the captured flag toward the output one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[LAST-1:0], d_i};
    end

    assign first_o = shreg[0];
    assign q_o     = shreg[LAST];
endmodule

// File: rtl/short_pulse_sync.sv
// short_pulse_sync: catches input events that may be shorter than a clock
// period and presents them as a level in the clk domain. The capture flag
// feeds a synchronizer chain, and the chain's output releases the flag once
// the input is idle again. Assumes pulses of one event are spaced so the
// flag is clear before the next one arrives.
module short_pulse_sync
    import short_pulse_sync_pkg::*;
#(
    parameter edge_sel_e EDGE   = EDGE_RISE,
    parameter int        STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic cap_flag;
    logic chain_first;

    pulse_capture #(.EDGE(EDGE)) u_capture (
        .async_in  (async_in),
        .rst_n     (rst_n),
        .release_i (sync_out),
        .flag_o    (cap_flag)
    );

    sync_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_i     (cap_flag),
        .first_o (chain_first),
        .q_o     (sync_out)
    );
endmodule

// File: rtl/short_pulse_sync_chk.sv
// short_pulse_sync_chk: properties over the synchronizer's ports and its
// capture flag / first chain stage. Attached through bind.
module short_pulse_sync_chk
    import short_pulse_sync_pkg::*;
#(
    parameter edge_sel_e EDGE = EDGE_RISE
) (
    input logic clk,
    input logic rst_n,
    input logic async_in,
    input logic sync_out,
    input logic cap_flag,
    input logic chain_first
);
    logic in_idle;
    assign in_idle = (EDGE == EDGE_RISE) ? ~async_in : async_in;

    // R1: reset forces the output low.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !sync_out);

    // R3: the chain only starts an event from a set capture flag.
    assert_chain_from_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_first) |-> $past(cap_flag));

    // R4: an output event is at least two cycles long.
    assert_min_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |=> sync_out);

    // R7: the flag drops only with the output high and the input idle.
    assert_clear_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_flag) |-> (sync_out && in_idle));
endmodule

bind short_pulse_sync short_pulse_sync_chk #(.EDGE(EDGE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .async_in    (async_in),
    .sync_out    (sync_out),
    .cap_flag    (cap_flag),
    .chain_first (chain_first)
);

// File: tb/short_pulse_sync_test.sv
// Directed bench: one task per scenario, run on a rising and a falling copy.
module short_pulse_sync_test;
    import short_pulse_sync_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_r = 1'b0;
    logic in_f = 1'b1;
    logic out_r;
    logic out_f;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    short_pulse_sync #(.EDGE(EDGE_RISE), .STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .async_in(in_r), .sync_out(out_r));

    short_pulse_sync #(.EDGE(EDGE_FALL), .STAGES(2)) uut_fall (
        .clk(clk), .rst_n(rst_n), .async_in(in_f), .sync_out(out_f));

    // Record one check and report a mismatch.
    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sample an output at n negedges; count events, first-high index, first width.
    task automatic measure(input bit fall, input int n,
                           output int evts, output int first, output int width);
        bit prev = 1'b0;
        evts = 0; first = 0; width = 0;
        for (int i = 1; i <= n; i++) begin
            bit v;
            @(negedge clk);
            v = fall ? out_f : out_r;
            if (v && !prev) begin
                evts++;
                if (evts == 1) first = i;
            end
            if (v && evts == 1) width++;
            prev = v;
        end
    endtask

    // Drive the active level on the chosen copy.
    task automatic set_active(input bit fall, input bit act);
        if (fall) in_f = ~act;
        else      in_r = act;
    endtask

    // R1: pulse during reset is discarded, output stays low.
    task automatic test_reset();
        int e, f, w;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 rise out in reset", out_r, 0);
        check("R1 fall out in reset", out_f, 0);
        #1 set_active(0, 1); set_active(1, 1);
        #2 set_active(0, 0); set_active(1, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        measure(0, 8, e, f, w);
        check("R1 rise no event after reset", e, 0);
    endtask

    // R2: idle input gives no event on either copy.
    task automatic test_idle();
        int e, f, w;
        fork
            measure(0, 10, e, f, w);
        join
        check("R2 rise idle", e, 0);
        measure(1, 6, e, f, w);
        check("R2 fall idle", e, 0);
    endtask

    // R9/R3/R4: sub-cycle pulse gives one event, latency 3 samples, width 2.
    task automatic test_short(input bit fall, input string tag);
        int e, f, w;
        @(posedge clk);
        fork
            begin #2 set_active(fall, 1); #3 set_active(fall, 0); end
            measure(fall, 12, e, f, w);
        join
        check({"R9 ", tag, " short events"}, e, 1);
        check({"R3 ", tag, " short latency"}, f, 3);
        check({"R4 ", tag, " short width"}, w, 2);
    endtask

    // R5/R7: held pulse of 5 cycles keeps output high 5 cycles.
    task automatic test_long(input bit fall, input string tag);
        int e, f, w;
        @(posedge clk);
        fork
            begin #2 set_active(fall, 1); #(5*CLK_PERIOD) set_active(fall, 0); end
            measure(fall, 16, e, f, w);
        join
        check({"R5 ", tag, " long events"}, e, 1);
        check({"R3 ", tag, " long latency"}, f, 3);
        check({"R7 ", tag, " long width"}, w, 5);
    endtask

    // R6: three pulses before the output rises merge into one event.
    task automatic test_burst(input bit fall, input string tag);
        int e, f, w;
        @(posedge clk);
        fork
            begin
                #2 set_active(fall, 1); #2 set_active(fall, 0);
                #2 set_active(fall, 1); #2 set_active(fall, 0);
                #4 set_active(fall, 1); #2 set_active(fall, 0);
            end
            measure(fall, 12, e, f, w);
        join
        check({"R6 ", tag, " burst events"}, e, 1);
        check({"R6 ", tag, " burst latency"}, f, 3);
        check({"R4 ", tag, " burst width"}, w, 2);
    endtask

    initial begin
        test_reset();
        test_idle();
        test_short(0, "rise");
        test_short(1, "R8 fall");
        test_long(0, "rise");
        test_long(1, "R8 fall");
        test_burst(0, "rise");
        test_burst(1, "R8 fall");
        repeat (4) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule